// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync Field

This block turns parallel words into a serial bit stream paced by a bit-clock enable. A start pulse opens a frame. The block then waits a programmed number of bit periods. When the sync option is on, it sends a sync pattern of programmed length taken from a configuration word. After that it sends a programmed number of payload words, each of programmed length, either most significant bit first or least significant bit first. The sync pattern uses the same bit order as the payload.

Payload words come in through a ready/valid port into a single holding register. Each time a word slot opens, the word in the holding register moves into the shifter. If the holding register is empty at that moment, the slot is filled with the idle level and an underrun pulse is raised. Outside a frame the data line carries a programmable idle level. The configuration inputs are expected to stay constant while a frame is running.

Top module: `sersync_tx`

## Requirements
- R1: While `frame_active` is low, `txd` equals `cfg_idle_lvl`. After reset `frame_active`, `sync_flag` and `underrun` are 0 and `word_ready` is 1.
- R2: A start is accepted on a clock edge where `bit_en` and `start_i` are both 1 and no frame is running (including its delay phase). For exactly one clock after that edge `sync_flag` is 1 and `frame_active` is 0.
- R3: With `cfg_delay` = D, the first frame bit appears on `txd` after the (D+1)th `bit_en` edge that follows the accepting edge. During the D edges before it, `txd` stays at the idle level and `frame_active` stays low.
- R4: With `cfg_sync_en` = 1, the frame begins with `cfg_sync_len_m1`+1 bits of `cfg_sync_data`, in the order selected by `cfg_msb_first`. With `cfg_sync_en` = 0, no sync bits are sent.
- R5: After the sync field, `cfg_nwords_m1`+1 words follow back to back, each `cfg_wlen_m1`+1 bits long, with one bit per `bit_en` edge.
- R6: With `cfg_msb_first` = 1, bit index `cfg_wlen_m1` of a word is sent first and bit 0 last. With `cfg_msb_first` = 0, bit 0 is sent first.
- R7: `frame_active` is 1 from the first sync or data bit through the last data bit. It falls on the next `bit_en` edge, when `txd` returns to the idle level.
- R8: `txd` and `frame_active` change only after clock edges on which `bit_en` was 1.
- R9: If the holding register is empty when a word slot opens, `txd` carries `cfg_idle_lvl` for the whole slot. `underrun` is then 1 for one clock after the slot's first edge, and the frame still runs to its full length.
- R10: A start pulse that arrives while a frame is running has no effect: `sync_flag` stays 0, and the frame ends at its normal length.
- R11: `word_ready` is 1 exactly when the holding register is empty. A word accepted with `word_valid` and `word_ready` both 1 stays held, with `word_ready` at 0, until a word slot takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one bit period per high cycle |
| start_i | input | 1 | Frame start request |
| cfg_delay | input | DLY_W | Start delay in bit periods |
| cfg_wlen_m1 | input | $clog2(DATA_W) | Word length minus one |
| cfg_nwords_m1 | input | NW_W | Words per frame minus one |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_sync_en | input | 1 | Send the sync field |
| cfg_sync_len_m1 | input | $clog2(SYNC_W) | Sync field length minus one |
| cfg_sync_data | input | SYNC_W | Sync pattern |
| cfg_idle_lvl | input | 1 | Line level outside frames and in underrun slots |
| word_data | input | DATA_W | Payload word |
| word_valid | input | 1 | Payload word offered |
| word_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial data |
| frame_active | output | 1 | Sync or data bits are on the line |
| sync_flag | output | 1 | One-clock pulse on an accepted start |
| underrun | output | 1 | One-clock pulse on a slot that had no word |

## Verification
The bench checks frames bit by bit against sequences it builds from the configuration. A design that used the wrong bit order, or dropped or added a sync or data bit, would produce a mismatch or leave `frame_active` high for the wrong time. An off-by-one in the start delay would shift every bit by one period. When `bit_en` has gaps, the bench confirms the line holds its value between edges; a design that shifted on every clock would break this. A word slot with no word must show the idle level and a single underrun pulse; a design that resent the old word or stalled the frame would fail. A start request in the middle of a frame must neither pulse the sync flag nor restart the frame.

// File: rtl/tx_sync_pkg.sv
package tx_sync_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_SYNC  = 2'd2,
      ST_DATA  = 2'd3
   } txs_state_e;

endpackage

// File: rtl/tx_hold_reg.sv
// One-word holding register between the ready/valid port and the shifter.
module tx_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         take,
   output logic [W-1:0] out_data,
   output logic         out_full
);

   logic         full_q;
   logic [W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end
   end

   assign in_ready = !full_q;
   assign out_full = full_q;
   assign out_data = data_q;

endmodule

// File: rtl/tx_bit_pick.sv
// Selects one bit of a vector by position, in either bit order.
module tx_bit_pick #(
   parameter int W  = 16,
   parameter int PW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   input  logic [PW-1:0] pos,
   input  logic [PW-1:0] last,
   input  logic          msb_first,
   output logic          bit_o
);

   logic [PW-1:0] idx;
   logic [W-1:0]  hit;

   assign idx = msb_first ? (last - pos) : pos;

   for (genvar i = 0; i < W; i++) begin : g_sel
      assign hit[i] = (idx == PW'(i)) & vec[i];
   end

   assign bit_o = |hit;

endmodule

// File: rtl/sersync_tx.sv
module sersync_tx
   import tx_sync_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SYNC_W = 16,
   parameter int DLY_W  = 8,
   parameter int NW_W   = 8,
   localparam int DPW   = $clog2(DATA_W),
   localparam int SPW   = $clog2(SYNC_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              start_i,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic [DPW-1:0]    cfg_wlen_m1,
   input  logic [NW_W-1:0]   cfg_nwords_m1,
   input  logic              cfg_msb_first,
   input  logic              cfg_sync_en,
   input  logic [SPW-1:0]    cfg_sync_len_m1,
   input  logic [SYNC_W-1:0] cfg_sync_data,
   input  logic              cfg_idle_lvl,
   input  logic [DATA_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_ready,
   output logic              txd,
   output logic              frame_active,
   output logic              sync_flag,
   output logic              underrun
);

   localparam int BCW = (DPW > SPW) ? DPW : SPW;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("sersync_tx: DATA_W must be at least 2");
   end
   if (SYNC_W < 2) begin : g_bad_sync_w
      $error("sersync_tx: SYNC_W must be at least 2");
   end
   if (DLY_W < 1 || NW_W < 1) begin : g_bad_cnt_w
      $error("sersync_tx: DLY_W and NW_W must be at least 1");
   end

   txs_state_e        state_q;
   logic [DLY_W-1:0]  dly_q;
   logic [BCW-1:0]    bcnt_q;
   logic [NW_W-1:0]   wcnt_q;
   logic [DATA_W-1:0] cur_q;
   logic              empty_slot_q;
   logic              sync_q;
   logic              under_q;

   logic [DATA_W-1:0] hold_data;
   logic              hold_full;
   logic              start_ok;
   logic              data_last;
   logic              sync_last;
   logic              word_open;
   logic              data_bit;
   logic              sync_bit;

   assign start_ok  = bit_en && start_i && (state_q == ST_IDLE);
   assign data_last = (bcnt_q[DPW-1:0] == cfg_wlen_m1);
   assign sync_last = (bcnt_q[SPW-1:0] == cfg_sync_len_m1);

   // a new word slot opens on this bit edge
   always_comb begin
      word_open = 1'b0;
      if (bit_en) begin
         unique case (state_q)
            ST_DELAY: word_open = (dly_q == '0) && !cfg_sync_en;
            ST_SYNC:  word_open = sync_last;
            ST_DATA:  word_open = data_last && (wcnt_q != cfg_nwords_m1);
            default:  word_open = 1'b0;
         endcase
      end
   end

   tx_hold_reg #(.W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (word_data),
      .in_valid (word_valid),
      .in_ready (word_ready),
      .take     (word_open && hold_full),
      .out_data (hold_data),
      .out_full (hold_full)
   );

   tx_bit_pick #(.W(DATA_W), .PW(DPW)) u_pick_data (
      .vec       (cur_q),
      .pos       (bcnt_q[DPW-1:0]),
      .last      (cfg_wlen_m1),
      .msb_first (cfg_msb_first),
      .bit_o     (data_bit)
   );

   tx_bit_pick #(.W(SYNC_W), .PW(SPW)) u_pick_sync (
      .vec       (cfg_sync_data),
      .pos       (bcnt_q[SPW-1:0]),
      .last      (cfg_sync_len_m1),
      .msb_first (cfg_msb_first),
      .bit_o     (sync_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         dly_q        <= '0;
         bcnt_q       <= '0;
         wcnt_q       <= '0;
         cur_q        <= '0;
         empty_slot_q <= 1'b0;
         sync_q       <= 1'b0;
         under_q      <= 1'b0;
      end else begin
         sync_q  <= start_ok;
         under_q <= word_open && !hold_full;
         if (bit_en) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (start_i) begin
                     state_q <= ST_DELAY;
                     dly_q   <= cfg_delay;
                     wcnt_q  <= '0;
                  end
               end
               ST_DELAY: begin
                  if (dly_q != '0) begin
                     dly_q <= dly_q - 1'b1;
                  end else if (cfg_sync_en) begin
                     state_q <= ST_SYNC;
                     bcnt_q  <= '0;
                  end else begin
                     state_q <= ST_DATA;
                  end
               end
               ST_SYNC: begin
                  if (sync_last) begin
                     state_q <= ST_DATA;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (data_last) begin
                     if (wcnt_q == cfg_nwords_m1) begin
                        state_q <= ST_IDLE;
                     end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                     end
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
            if (word_open) begin
               bcnt_q       <= '0;
               cur_q        <= hold_data;
               empty_slot_q <= !hold_full;
            end
         end
      end
   end

   always_comb begin
      unique case (state_q)
         ST_SYNC: txd = sync_bit;
         ST_DATA: txd = empty_slot_q ? cfg_idle_lvl : data_bit;
         default: txd = cfg_idle_lvl;
      endcase
   end

   assign frame_active = (state_q == ST_SYNC) || (state_q == ST_DATA);
   assign sync_flag    = sync_q;
   assign underrun     = under_q;

endmodule

// File: rtl/tx_sync_chk.sv
module tx_sync_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic start_i,
   input logic word_valid,
   input logic word_ready,
   input logic txd,
   input logic frame_active,
   input logic sync_flag,
   input logic underrun,
   input logic cfg_idle_lvl
);

   p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_active |-> (txd == cfg_idle_lvl));

   p_sync_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_flag |-> $past(bit_en && start_i));

   p_sync_before_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_flag |-> !frame_active);

   p_active_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(frame_active));

   p_underrun_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> frame_active);

   p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && bit_en && start_i) |=> !sync_flag);

   p_hold_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready) |=> !word_ready);

endmodule

bind sersync_tx tx_sync_chk u_chk (.*);

// File: tb/sim_sersync_tx.sv
`timescale 1ns/1ps
module sim_sersync_tx;

   localparam int DW = 16;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_en = 1'b0;
   logic          start_i = 1'b0;
   logic [7:0]    cfg_delay = '0;
   logic [3:0]    cfg_wlen_m1 = '0;
   logic [7:0]    cfg_nwords_m1 = '0;
   logic          cfg_msb_first = 1'b1;
   logic          cfg_sync_en = 1'b0;
   logic [3:0]    cfg_sync_len_m1 = '0;
   logic [SW-1:0] cfg_sync_data = '0;
   logic          cfg_idle_lvl = 1'b0;
   logic [DW-1:0] word_data = '0;
   logic          word_valid = 1'b0;
   logic          word_ready;
   logic          txd;
   logic          frame_active;
   logic          sync_flag;
   logic          underrun;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   int gap = 0;

   logic [DW-1:0] words [8];
   logic          exp_q [$];

   logic s_tx, s_act, s_sync, s_under;
   bit   stable_bad;

   always #4 clk = ~clk;

   sersync_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_i(start_i),
      .cfg_delay(cfg_delay), .cfg_wlen_m1(cfg_wlen_m1),
      .cfg_nwords_m1(cfg_nwords_m1), .cfg_msb_first(cfg_msb_first),
      .cfg_sync_en(cfg_sync_en), .cfg_sync_len_m1(cfg_sync_len_m1),
      .cfg_sync_data(cfg_sync_data), .cfg_idle_lvl(cfg_idle_lvl),
      .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
      .txd(txd), .frame_active(frame_active), .sync_flag(sync_flag),
      .underrun(underrun)
   );

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
         summary();
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one bit-enable edge, then gap quiet cycles; entered and left at a negedge
   task automatic pulse_en(input logic st);
      bit_en  = 1'b1;
      start_i = st;
      @(posedge clk);
      @(negedge clk);
      bit_en  = 1'b0;
      start_i = 1'b0;
      s_tx    = txd;
      s_act   = frame_active;
      s_sync  = sync_flag;
      s_under = underrun;
      for (int g = 0; g < gap; g++) begin
         @(posedge clk);
         @(negedge clk);
         if (txd !== s_tx || frame_active !== s_act) stable_bad = 1;
      end
   endtask

   task automatic feed_words(input int first, input int last);
      @(negedge clk);
      for (int i = first; i < last; i++) begin
         logic rdy;
         word_valid = 1'b1;
         word_data  = words[i];
         do begin
            rdy = word_ready;
            @(posedge clk);
            @(negedge clk);
         end while (!rdy);
         word_valid = 1'b0;
      end
   endtask

   // frame with navail words present (words[fbase..navail-1] fed by the bench)
   task automatic run_frame(input string req, input int dly, input int wl,
                            input int nw, input logic msb, input logic sen,
                            input int sl, input logic idle, input int g,
                            input int navail, input int fbase, input bit mid_start);
      int bad_tx = 0, bad_act = 0, n_under = 0, first_bad = -1;
      bit quiet_bad = 0;
      logic mid_sync = 1'b0;
      cfg_delay = 8'(dly); cfg_wlen_m1 = 4'(wl); cfg_nwords_m1 = 8'(nw);
      cfg_msb_first = msb; cfg_sync_en = sen; cfg_sync_len_m1 = 4'(sl);
      cfg_idle_lvl = idle; gap = g; stable_bad = 0;
      exp_q.delete();
      if (sen) for (int i = 0; i <= sl; i++) exp_q.push_back(cfg_sync_data[msb ? sl - i : i]);
      for (int w = 0; w <= nw; w++)
         for (int i = 0; i <= wl; i++)
            exp_q.push_back(w < navail ? words[w][msb ? wl - i : i] : idle);
      if (navail > fbase) begin
         fork
            feed_words(fbase, navail);
         join_none
      end
      repeat (3) @(negedge clk);
      pulse_en(1'b1);
      chk("R2", "sync_flag after start", int'(s_sync), 1);
      chk("R2", "frame_active at start", int'(s_act), 0);
      for (int d = 0; d < dly; d++) begin
         pulse_en(1'b0);
         if (s_act !== 1'b0 || s_tx !== idle) quiet_bad = 1;
      end
      chk("R3", "line quiet during start delay", int'(quiet_bad), 0);
      for (int i = 0; i < exp_q.size(); i++) begin
         pulse_en(mid_start && i == 1);
         if (mid_start && i == 1) mid_sync = s_sync;
         if (s_tx !== exp_q[i]) begin
            bad_tx++;
            if (first_bad < 0) first_bad = i;
         end
         if (s_act !== 1'b1) bad_act++;
         if (s_under === 1'b1) n_under++;
      end
      if (bad_tx != 0) $display("  first bad bit index %0d", first_bad);
      chk(req, "mismatched serial bits", bad_tx, 0);
      chk("R7", "bits with frame_active low", bad_act, 0);
      chk("R9", "underrun pulses", n_under, (navail > nw) ? 0 : nw + 1 - navail);
      if (g > 0) chk("R8", "output moved between enables", int'(stable_bad), 0);
      if (mid_start) chk("R10", "sync_flag on busy start", int'(mid_sync), 0);
      pulse_en(1'b0);
      chk("R7", "frame_active after last bit", int'(s_act), 0);
      chk("R1", "idle level after frame", int'(s_tx), int'(idle));
      if (mid_start) begin
         pulse_en(1'b0);
         chk("R10", "no frame restarted", int'(s_act), 0);
      end
      gap = 0;
   endtask

   task automatic t_reset();
      chk("R1", "frame_active in reset", int'(frame_active), 0);
      chk("R1", "sync_flag in reset", int'(sync_flag), 0);
      chk("R1", "underrun in reset", int'(underrun), 0);
      chk("R11", "word_ready in reset", int'(word_ready), 1);
      cfg_idle_lvl = 1'b1;
      #1;
      chk("R1", "idle level high", int'(txd), 1);
      cfg_idle_lvl = 1'b0;
      #1;
      chk("R1", "idle level low", int'(txd), 0);
   endtask

   task automatic t_msb_basic();
      words[0] = 16'h00B4; words[1] = 16'h0063;
      run_frame("R6", 0, 7, 1, 1'b1, 1'b0, 0, 1'b0, 0, 2, 0, 0);
   endtask

   task automatic t_sync_lsb();
      cfg_sync_data = 16'hA5C3;
      words[0] = 16'h0A71; words[1] = 16'h05EC; words[2] = 16'h0F02;
      run_frame("R4", 3, 11, 2, 1'b0, 1'b1, 4, 1'b1, 2, 3, 0, 0);
   endtask

   task automatic t_words_lsb();
      words[0] = 16'h0013; words[1] = 16'h002C; words[2] = 16'h0035; words[3] = 16'h0008;
      run_frame("R5", 2, 5, 3, 1'b0, 1'b0, 0, 1'b0, 1, 4, 0, 0);
   endtask

   task automatic t_underrun();
      words[0] = 16'h0016;
      run_frame("R9", 1, 5, 2, 1'b1, 1'b0, 0, 1'b1, 1, 1, 0, 0);
   endtask

   task automatic t_busy_start();
      cfg_sync_data = 16'h6B1E;
      words[0] = 16'h0009;
      run_frame("R3", 10, 3, 0, 1'b1, 1'b1, 15, 1'b0, 0, 1, 0, 1);
   endtask

   task automatic t_hold();
      words[0] = 16'h00C5; words[1] = 16'h003A;
      @(negedge clk);
      word_valid = 1'b1;
      word_data  = words[0];
      @(posedge clk);
      @(negedge clk);
      word_valid = 1'b0;
      chk("R11", "word_ready after accept", int'(word_ready), 0);
      repeat (5) @(negedge clk);
      chk("R11", "word_ready while held", int'(word_ready), 0);
      run_frame("R11", 0, 7, 1, 1'b1, 1'b0, 0, 1'b0, 0, 2, 1, 0);
      chk("R11", "word_ready after frame", int'(word_ready), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_msb_basic();
      t_sync_lsb();
      t_words_lsb();
      t_underrun();
      t_busy_start();
      t_hold();
      repeat (4) @(negedge clk);
      summary();
   end

endmodule